// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This block takes two vector operands and combines neighbouring elements inside each operand. Each pair is an even-indexed element and the odd-indexed element just above it. The pair results of operand A fill the lower part of the output and the pair results of operand B fill the part above them. Elements can be 16-bit words or 32-bit dwords.

The pair operation is addition or subtraction. Subtraction always takes the even element minus the odd element. Word results either wrap or clamp to the signed 16-bit range. Dword results always wrap. A mode input selects the register width. In the full 128-bit mode the whole of both operands is used. In the 64-bit mode only the low 64 bits of each operand are used.

The result is registered one cycle after an accepted request, and the output valid flag tracks the input valid flag with the same one-cycle delay. Asking for saturation with dword elements is flagged as an illegal operation and returns zero.

Top module: `pair_hsum_unit`

## Requirements
- R1: While reset is asserted and after its release, before any request, `out_valid`, `out_illegal` and `out_result` are all zero.
- R2: `out_valid` in a cycle equals `in_valid` of the previous cycle. The result of a request accepted at a clock edge is on `out_result` right after that edge.
- R3: In a cycle with `in_valid` low, `out_result` and `out_illegal` keep their previous values.
- R4: Element k of an operand occupies bits [k*E +: E], where E is 16 for words and 32 for dwords. With P pairs per operand, result slot i (0 ≤ i < P) holds pair i of A, and slot P+i holds pair i of B.
- R5: With `op_sub`=1, each pair result is element 2i minus element 2i+1. With `op_sub`=0 it is their sum.
- R6: Word pairs with `op_sat`=0 wrap modulo 2^16.
- R7: Word pairs with `op_sat`=1 clamp to 0x7FFF (+32767) on positive overflow and to 0x8000 (−32768) on negative overflow.
- R8: Dword pairs (`op_dword`=1, `op_sat`=0) wrap modulo 2^32.
- R9: With `wide_mode`=0, only bits [63:0] of each operand are read. The A pairs come first and the B pairs follow, packed into bits [63:0], and bits [127:64] are zero. With `wide_mode`=1, the full 128 bits of each operand are used.
- R10: A request with `op_sat`=1 and `op_dword`=1 sets `out_illegal` and produces an all-zero result. Every other request clears `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| op_sub | input | 1 | 1 = even minus odd, 0 = sum |
| op_sat | input | 1 | 1 = signed saturation (words only) |
| op_dword | input | 1 | 1 = 32-bit elements, 0 = 16-bit elements |
| wide_mode | input | 1 | 1 = 128-bit registers, 0 = 64-bit registers |
| src_a | input | 128 | Operand A |
| src_b | input | 128 | Operand B |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_illegal | output | 1 | Saturating dword request was seen |
| out_result | output | 128 | Packed pair results |

## Verification
Operands with a distinct value in every element are used to check the slot ordering. With them, a swapped pair, a swapped operand half or a misplaced narrow packing each changes the output. Pairs whose sum or difference crosses ±2^15 are run with saturation both on and off. This separates clamping from wrapping, and it also exposes a reversed subtraction order, because a−b and b−a overflow differently. In the 64-bit mode the upper operand bits are filled with nonzero data, to show they are ignored. Random mixes of all four controls are interleaved with idle cycles, which exercises both the hold behaviour and the illegal-combination flag.

// File: rtl/hs_pkg.sv
package hs_pkg;
    localparam int WORD_W  = 16;
    localparam int DWORD_W = 32;
    localparam logic [WORD_W-1:0] WORD_MAX = 16'h7FFF;
    localparam logic [WORD_W-1:0] WORD_MIN = 16'h8000;
endpackage

// File: rtl/hs_word_pair.sv
module hs_word_pair
    import hs_pkg::*;
(
    input  logic [WORD_W-1:0] even_i,
    input  logic [WORD_W-1:0] odd_i,
    input  logic              sub_i,
    input  logic              sat_i,
    output logic [WORD_W-1:0] res_o
);
    logic [WORD_W:0] ext_sum;
    logic            ovf;

    always_comb begin
        if (sub_i) begin
            ext_sum = {even_i[WORD_W-1], even_i} - {odd_i[WORD_W-1], odd_i};
        end else begin
            ext_sum = {even_i[WORD_W-1], even_i} + {odd_i[WORD_W-1], odd_i};
        end
        ovf = ext_sum[WORD_W] != ext_sum[WORD_W-1];
        if (sat_i && ovf) begin
            res_o = ext_sum[WORD_W] ? WORD_MIN : WORD_MAX;
        end else begin
            res_o = ext_sum[WORD_W-1:0];
        end
    end
endmodule

// File: rtl/hs_dword_pair.sv
module hs_dword_pair
    import hs_pkg::*;
(
    input  logic [DWORD_W-1:0] even_i,
    input  logic [DWORD_W-1:0] odd_i,
    input  logic               sub_i,
    output logic [DWORD_W-1:0] res_o
);
    always_comb begin
        res_o = sub_i ? (even_i - odd_i) : (even_i + odd_i);
    end
endmodule

// File: rtl/hs_pack.sv
module hs_pack #(
    parameter int VEC_W = 128
) (
    input  logic [VEC_W/2-1:0] a_flat_i,
    input  logic [VEC_W/2-1:0] b_flat_i,
    input  logic               wide_i,
    output logic [VEC_W-1:0]   packed_o
);
    localparam int HALF = VEC_W / 2;
    localparam int QTR  = VEC_W / 4;

    always_comb begin
        packed_o = '0;
        if (wide_i) begin
            packed_o = {b_flat_i, a_flat_i};
        end else begin
            packed_o[HALF-1:0] = {b_flat_i[QTR-1:0], a_flat_i[QTR-1:0]};
        end
    end
endmodule

// File: rtl/pair_hsum_unit.sv
module pair_hsum_unit
    import hs_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             op_sub,
    input  logic             op_sat,
    input  logic             op_dword,
    input  logic             wide_mode,
    input  logic [VEC_W-1:0] src_a,
    input  logic [VEC_W-1:0] src_b,
    output logic             out_valid,
    output logic             out_illegal,
    output logic [VEC_W-1:0] out_result
);
    localparam int HALF   = VEC_W / 2;
    localparam int WPAIRS = VEC_W / WORD_W / 2;
    localparam int DPAIRS = VEC_W / DWORD_W / 2;

    typedef struct packed {
        logic             valid;
        logic             illegal;
        logic [VEC_W-1:0] result;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [HALF-1:0]  a_wflat, b_wflat, a_dflat, b_dflat;
    logic [VEC_W-1:0] word_packed, dword_packed;

    for (genvar g = 0; g < WPAIRS; g++) begin : g_words
        hs_word_pair u_a (
            .even_i(src_a[2*g*WORD_W +: WORD_W]),
            .odd_i (src_a[(2*g+1)*WORD_W +: WORD_W]),
            .sub_i (op_sub),
            .sat_i (op_sat),
            .res_o (a_wflat[g*WORD_W +: WORD_W])
        );
        hs_word_pair u_b (
            .even_i(src_b[2*g*WORD_W +: WORD_W]),
            .odd_i (src_b[(2*g+1)*WORD_W +: WORD_W]),
            .sub_i (op_sub),
            .sat_i (op_sat),
            .res_o (b_wflat[g*WORD_W +: WORD_W])
        );
    end

    for (genvar g = 0; g < DPAIRS; g++) begin : g_dwords
        hs_dword_pair u_a (
            .even_i(src_a[2*g*DWORD_W +: DWORD_W]),
            .odd_i (src_a[(2*g+1)*DWORD_W +: DWORD_W]),
            .sub_i (op_sub),
            .res_o (a_dflat[g*DWORD_W +: DWORD_W])
        );
        hs_dword_pair u_b (
            .even_i(src_b[2*g*DWORD_W +: DWORD_W]),
            .odd_i (src_b[(2*g+1)*DWORD_W +: DWORD_W]),
            .sub_i (op_sub),
            .res_o (b_dflat[g*DWORD_W +: DWORD_W])
        );
    end

    hs_pack #(.VEC_W(VEC_W)) u_pack_w (
        .a_flat_i(a_wflat),
        .b_flat_i(b_wflat),
        .wide_i  (wide_mode),
        .packed_o(word_packed)
    );

    hs_pack #(.VEC_W(VEC_W)) u_pack_d (
        .a_flat_i(a_dflat),
        .b_flat_i(b_dflat),
        .wide_i  (wide_mode),
        .packed_o(dword_packed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.illegal = op_sat && op_dword;
            if (op_sat && op_dword) begin
                st_d.result = '0;
            end else if (op_dword) begin
                st_d.result = dword_packed;
            end else begin
                st_d.result = word_packed;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid   = st_q.valid;
    assign out_illegal = st_q.illegal;
    assign out_result  = st_q.result;
endmodule

// File: rtl/hs_checker.sv
module hs_checker #(
    parameter int VEC_W = 128
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             op_sat,
    input logic             op_dword,
    input logic             wide_mode,
    input logic             out_valid,
    input logic             out_illegal,
    input logic [VEC_W-1:0] out_result
);
    localparam int HALF = VEC_W / 2;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_result) && $stable(out_illegal))); // R3
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide_mode) |=> (out_result[VEC_W-1:HALF] == '0)); // R9
    AST_ILLEGAL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (out_illegal == $past(op_sat && op_dword))); // R10
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_result == '0)); // R10
endmodule

bind pair_hsum_unit hs_checker #(.VEC_W(VEC_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_sat     (op_sat),
    .op_dword   (op_dword),
    .wide_mode  (wide_mode),
    .out_valid  (out_valid),
    .out_illegal(out_illegal),
    .out_result (out_result)
);

// File: tb/pair_hsum_unit_tb_top.sv
module pair_hsum_unit_tb_top;
    localparam int VW = 128;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0, op_sub = 1'b0, op_sat = 1'b0;
    logic          op_dword = 1'b0, wide_mode = 1'b0;
    logic [VW-1:0] src_a = '0, src_b = '0;
    logic          out_valid, out_illegal;
    logic [VW-1:0] out_result;

    int compared = 0;
    int mismatched = 0;

    logic          exp_v = 1'b0, exp_ill = 1'b0;
    logic [VW-1:0] exp_res = '0;

    always #10 clk = ~clk;

    pair_hsum_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sub(op_sub),
        .op_sat(op_sat), .op_dword(op_dword), .wide_mode(wide_mode),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid),
        .out_illegal(out_illegal), .out_result(out_result)
    );

    function automatic logic [VW-1:0] ref_calc(logic [VW-1:0] a, logic [VW-1:0] b,
                                               bit sub, bit sat, bit dw, bit wide);
        logic [VW-1:0] r;
        logic [VW-1:0] src;
        longint x, y, s;
        int np;
        r  = '0;
        np = (wide ? 128 : 64) / (dw ? 32 : 16) / 2;
        if (sat && dw) return '0;
        for (int k = 0; k < 2; k++) begin
            src = (k == 0) ? a : b;
            for (int i = 0; i < np; i++) begin
                if (dw) begin
                    x = longint'($signed(src[(2*i)*32 +: 32]));
                    y = longint'($signed(src[(2*i+1)*32 +: 32]));
                end else begin
                    x = longint'($signed(src[(2*i)*16 +: 16]));
                    y = longint'($signed(src[(2*i+1)*16 +: 16]));
                end
                s = sub ? (x - y) : (x + y);
                if (sat) begin
                    if (s > 32767) s = 32767;
                    if (s < -32768) s = -32768;
                end
                if (dw) r[(k*np+i)*32 +: 32] = s[31:0];
                else    r[(k*np+i)*16 +: 16] = s[15:0];
            end
        end
        return r;
    endfunction

    task automatic check(bit ok, string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Drive at negedge, compare at the following negedge (one register on the path).
    task automatic step(bit v, logic [VW-1:0] a, logic [VW-1:0] b,
                        bit sub, bit sat, bit dw, bit wide, string tag);
        in_valid = v; src_a = a; src_b = b;
        op_sub = sub; op_sat = sat; op_dword = dw; wide_mode = wide;
        if (v) begin
            exp_res = ref_calc(a, b, sub, sat, dw, wide);
            exp_ill = sat && dw;
        end
        exp_v = v;
        @(negedge clk);
        check(out_valid == exp_v, "R2 valid", {127'd0, out_valid}, {127'd0, exp_v});
        check(out_result == exp_res, tag, out_result, exp_res);
        check(out_illegal == exp_ill, "R10 flag", {127'd0, out_illegal}, {127'd0, exp_ill});
    endtask

    function automatic logic [VW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    logic [VW-1:0] seq_a, seq_b;

    initial begin
        for (int k = 0; k < 16; k++) begin
            seq_a[k*8 +: 8] = 8'(k + 1);
            seq_b[k*8 +: 8] = 8'(8'h40 + k * 3);
        end
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_illegal == 1'b0 && out_result == '0, "R1 in reset",
              out_result, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_result == '0, "R1 after release", out_result, '0);

        step(1, seq_a, seq_b, 0, 0, 0, 1, "R4 word add order");
        step(1, seq_a, seq_b, 1, 0, 0, 1, "R5 word sub even-odd");
        step(1, seq_a, seq_b, 0, 0, 1, 1, "R8 dword add order");
        step(1, seq_a, seq_b, 1, 0, 1, 1, "R8 dword sub");
        step(0, rnd128(), rnd128(), 1, 1, 1, 0, "R3 idle hold");
        step(0, rnd128(), rnd128(), 0, 0, 0, 1, "R3 idle hold 2");
        // Overflow pairs: 0x7000+0x2000, 0x8000-0x0001, 0x9000+0xA000, 0x0001-0x8000
        step(1, {4{64'h8000_0001_A000_9000}}, {4{64'h0001_8000_2000_7000}}, 0, 0, 0, 1, "R6 word add wrap");
        step(1, {4{64'h8000_0001_A000_9000}}, {4{64'h0001_8000_2000_7000}}, 0, 1, 0, 1, "R7 word add sat");
        step(1, {4{64'h8000_0001_0001_8000}}, {4{64'h7FFF_FFFF_0002_7FFF}}, 1, 0, 0, 1, "R6 word sub wrap");
        step(1, {4{64'h8000_0001_0001_8000}}, {4{64'h7FFF_FFFF_0002_7FFF}}, 1, 1, 0, 1, "R7 word sub sat");
        step(1, {64'hDEAD_BEEF_1234_5678, seq_a[63:0]}, {64'hCAFE_F00D_8765_4321, seq_b[63:0]},
             0, 0, 0, 0, "R9 narrow word");
        step(1, {64'hDEAD_BEEF_1234_5678, seq_a[63:0]}, {64'hCAFE_F00D_8765_4321, seq_b[63:0]},
             1, 0, 1, 0, "R9 narrow dword");
        step(1, {2{64'hFFFF_FFFF_8000_0000}}, {2{64'h0000_0001_7FFF_FFFF}}, 0, 0, 1, 1, "R8 dword wrap");
        step(1, seq_a, seq_b, 0, 1, 1, 1, "R10 illegal zero");
        step(1, seq_a, seq_b, 0, 0, 0, 1, "R10 illegal cleared");
        for (int n = 0; n < 400; n++) begin
            logic [3:0] c;
            c = 4'($urandom);
            step(($urandom % 4) != 0, rnd128(), rnd128(), c[0], c[1], c[2], c[3], "R5 random mix");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 20);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule